// File: doc/BRIEF.md
# Crosspoint Switch Configuration Register Bank

This block is the configuration store and parallel host port of a wide crosspoint switch. A host reaches three banks of 68 seven-bit registers through a 7-bit channel address, a shared bidirectional 7-bit data bus, a read/write line, a write strobe, a bank-class select and a chip enable. One bank holds per-channel settings that the block decodes into equalizer code, line termination mode, output swing level and power enable for every channel. The other two banks hold per-output source selections for the switch matrix. They are plain readable storage here, and a second select line chooses between them.

Writes are edge-triggered. The block captures address and data on the first clock after the strobe rises, and a strobe that stays high does not write again. Reads are pipelined by one clock. The block drives the data bus only while it is enabled and in read mode, so host and block never fight over the bus.

Top module: `xpt_cfg_regs`

## Requirements
- R1: Addresses 0 to 67 select a register. With `ctl_sel`=1 the control bank is used. With `ctl_sel`=0, `bank_hi`=0 selects matrix bank 0 and `bank_hi`=1 selects matrix bank 1. The three banks are independent.
- R2: A write takes place only on a rising edge of `wr_strobe` (low in one clock, high in the next) with `chip_en`=1 and `rd_wr`=0. It stores `data_io` into the addressed register. Holding the strobe high stores nothing further.
- R3: With `chip_en`=1 and `rd_wr`=1, `data_io` carries the content of the register addressed in the previous clock.
- R4: The block leaves `data_io` undriven unless `chip_en`=1 and `rd_wr`=1.
- R5: With `chip_en`=0, strobe edges change no register.
- R6: Addresses 68 to 127 are undecoded. Writes to them are dropped and reads return 0.
- R7: Reset clears every control register, which gives equalizer 000, lowest swing, DC coupling and power on. The matrix banks start at zero and keep their contents through reset.
- R8: `eq_code` for channel n equals bits [2:0] of control register n.
- R9: `amp_lvl` for channel n equals bits [4:3] of control register n, except that the reserved value 3 is output as 2, the highest level.
- R10: Bit 5 of control register n drives `ac_term[n]`. Bit 6 is a power-down bit, so `pwr_en[n]` is its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en | input | 1 | Chip enable, active high |
| rd_wr | input | 1 | 1 = read, 0 = write |
| wr_strobe | input | 1 | Write strobe, rising edge stores |
| ctl_sel | input | 1 | 1 = control bank, 0 = matrix banks |
| bank_hi | input | 1 | Selects matrix bank 1 when `ctl_sel`=0 |
| ch_addr | input | 7 | Register address |
| data_io | inout | 7 | Bidirectional data bus |
| eq_code | output | 204 | 3-bit equalizer code per channel |
| amp_lvl | output | 136 | 2-bit swing level per channel |
| ac_term | output | 68 | AC termination bias enable per channel |
| pwr_en | output | 68 | Channel power enable |

## Verification
On every cycle the assertions check four things. Write enables are one-hot and are held off by a low chip enable or an undecoded address. Control registers hold when nothing is written, and the decoded swing level never shows the reserved code. A matrix register written and then addressed returns the written value. The cleared state is checked right after reset. Only the bench scenarios can show that data lands in the intended bank and address and comes back over the shared bus. They also show that a held strobe writes once, that a disabled chip leaves the bus to the host, and that the matrix banks survive a reset.

// File: rtl/xpt_cfg_pkg.sv
package xpt_cfg_pkg;

  typedef enum logic [1:0] {
    BK_CTL  = 2'd0,
    BK_MTX0 = 2'd1,
    BK_MTX1 = 2'd2,
    BK_NONE = 2'd3
  } bank_e;

  // control word field positions
  localparam int EQ_LSB  = 0;
  localparam int EQ_W    = 3;
  localparam int AMP_LSB = 3;
  localparam int AMP_W   = 2;
  localparam int ACT_BIT = 5;
  localparam int PD_BIT  = 6;

  // reserved swing code 3 saturates to the highest real level
  function automatic logic [AMP_W-1:0] amp_sat(input logic [AMP_W-1:0] raw);
    return (raw == 2'd3) ? 2'd2 : raw;
  endfunction

endpackage

// File: rtl/xpt_host_port.sv
module xpt_host_port
  import xpt_cfg_pkg::*;
#(
  parameter int NCH = 68,
  parameter int AW  = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chip_en,
  input  logic          rd_wr,
  input  logic          wr_strobe,
  input  logic          ctl_sel,
  input  logic          bank_hi,
  input  logic [AW-1:0] ch_addr,
  output logic          wr_ctl,
  output logic [1:0]    wr_mtx,
  output bank_e         rd_bank,
  output logic          bus_oe
);

  localparam logic [AW-1:0] LAST = AW'(NCH - 1);

  logic  stb_q;
  logic  in_range;
  logic  go;
  bank_e bank_sel;

  always_ff @(posedge clk) begin
    if (rst) stb_q <= 1'b1;
    else     stb_q <= wr_strobe;
  end

  assign in_range = (ch_addr <= LAST);
  assign go       = !rst && chip_en && !rd_wr && wr_strobe && !stb_q && in_range;

  always_comb begin
    if (ctl_sel)      bank_sel = BK_CTL;
    else if (bank_hi) bank_sel = BK_MTX1;
    else              bank_sel = BK_MTX0;
  end

  assign wr_ctl    = go && (bank_sel == BK_CTL);
  assign wr_mtx[0] = go && (bank_sel == BK_MTX0);
  assign wr_mtx[1] = go && (bank_sel == BK_MTX1);

  always_ff @(posedge clk) begin
    if (rst)           rd_bank <= BK_NONE;
    else if (in_range) rd_bank <= bank_sel;
    else               rd_bank <= BK_NONE;
  end

  assign bus_oe = chip_en && rd_wr;

  assert_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_ctl, wr_mtx}));

  assert_cs_gate_R5: assert property (@(posedge clk) disable iff (rst)
    !chip_en |-> !(wr_ctl || (|wr_mtx)));

  assert_no_oob_write_R6: assert property (@(posedge clk) disable iff (rst)
    (ch_addr > LAST) |-> !(wr_ctl || (|wr_mtx)));

  assert_edge_only_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl || (|wr_mtx)) |=> !(wr_ctl || (|wr_mtx)));

endmodule

// File: rtl/xpt_ctl_bank.sv
module xpt_ctl_bank
  import xpt_cfg_pkg::*;
#(
  parameter int NCH = 68,
  parameter int DW  = 7,
  parameter int AW  = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rd_q,
  output logic [NCH*EQ_W-1:0]  eq_code,
  output logic [NCH*AMP_W-1:0] amp_lvl,
  output logic [NCH-1:0]       ac_term,
  output logic [NCH-1:0]       pwr_en
);

  localparam logic [AW-1:0] LAST = AW'(NCH - 1);

  logic [DW-1:0]     regs [NCH];
  logic [NCH*DW-1:0] flat;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) regs[i] <= '0;
    end else if (we) begin
      regs[addr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              rd_q <= '0;
    else if (addr <= LAST) rd_q <= regs[addr];
    else                  rd_q <= '0;
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign flat[n*DW +: DW]         = regs[n];
    assign eq_code[n*EQ_W +: EQ_W]  = regs[n][EQ_LSB +: EQ_W];
    assign amp_lvl[n*AMP_W +: AMP_W] = amp_sat(regs[n][AMP_LSB +: AMP_W]);
    assign ac_term[n]               = regs[n][ACT_BIT];
    assign pwr_en[n]                = !regs[n][PD_BIT];

    assert_amp_sat_R9: assert property (@(posedge clk) disable iff (rst)
      amp_lvl[n*AMP_W +: AMP_W] != 2'd3);
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(flat));

  assert_reset_R7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ((&pwr_en) && (amp_lvl == '0) && (ac_term == '0) && (eq_code == '0)));

endmodule

// File: rtl/xpt_mtx_bank.sv
module xpt_mtx_bank #(
  parameter int NCH = 68,
  parameter int DW  = 7,
  parameter int AW  = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_q
);

  logic [DW-1:0] mem [NCH];

  initial begin
    for (int i = 0; i < NCH; i++) mem[i] = '0;
  end

  // single-port RAM, read-before-write, no reset on contents
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rd_q <= mem[addr];
  end

  assert_readback_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(we) && (addr == $past(addr))) |=> (rd_q == $past(wdata, 2)));

endmodule

// File: rtl/xpt_cfg_regs.sv
module xpt_cfg_regs
  import xpt_cfg_pkg::*;
#(
  parameter int NCH = 68,
  parameter int DW  = 7,
  parameter int AW  = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 chip_en,
  input  logic                 rd_wr,
  input  logic                 wr_strobe,
  input  logic                 ctl_sel,
  input  logic                 bank_hi,
  input  logic [AW-1:0]        ch_addr,
  inout  wire  [DW-1:0]        data_io,
  output logic [NCH*EQ_W-1:0]  eq_code,
  output logic [NCH*AMP_W-1:0] amp_lvl,
  output logic [NCH-1:0]       ac_term,
  output logic [NCH-1:0]       pwr_en
);

  localparam int NMTX = 2;

  logic            wr_ctl;
  logic [NMTX-1:0] wr_mtx;
  bank_e           rd_bank;
  logic            bus_oe;
  logic [DW-1:0]   ctl_rd;
  logic [DW-1:0]   mtx_rd [NMTX];
  logic [DW-1:0]   rd_mux;
  logic [DW-1:0]   wdata;

  assign wdata = data_io;

  xpt_host_port #(.NCH(NCH), .AW(AW)) u_port (
    .clk(clk), .rst(rst), .chip_en(chip_en), .rd_wr(rd_wr),
    .wr_strobe(wr_strobe), .ctl_sel(ctl_sel), .bank_hi(bank_hi),
    .ch_addr(ch_addr), .wr_ctl(wr_ctl), .wr_mtx(wr_mtx),
    .rd_bank(rd_bank), .bus_oe(bus_oe)
  );

  xpt_ctl_bank #(.NCH(NCH), .DW(DW), .AW(AW)) u_ctl (
    .clk(clk), .rst(rst), .we(wr_ctl), .addr(ch_addr), .wdata(wdata),
    .rd_q(ctl_rd), .eq_code(eq_code), .amp_lvl(amp_lvl),
    .ac_term(ac_term), .pwr_en(pwr_en)
  );

  for (genvar g = 0; g < NMTX; g++) begin : g_mtx
    xpt_mtx_bank #(.NCH(NCH), .DW(DW), .AW(AW)) u_mtx (
      .clk(clk), .rst(rst), .we(wr_mtx[g]), .addr(ch_addr),
      .wdata(wdata), .rd_q(mtx_rd[g])
    );
  end

  always_comb begin
    case (rd_bank)
      BK_CTL:  rd_mux = ctl_rd;
      BK_MTX0: rd_mux = mtx_rd[0];
      BK_MTX1: rd_mux = mtx_rd[1];
      default: rd_mux = '0;
    endcase
  end

  assign data_io = bus_oe ? rd_mux : 'z;

endmodule

// File: tb/xpt_cfg_regs_bench.sv
`timescale 1ns/1ps
module xpt_cfg_regs_bench;

  localparam int NCH = 68;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chip_en = 1'b0, rd_wr = 1'b0, wr_strobe = 1'b0, ctl_sel = 1'b0, bank_hi = 1'b0;
  logic [6:0] ch_addr = '0;
  logic hdrv = 1'b0;
  logic [6:0] hval = '0;
  wire  [6:0] data_io;
  logic [NCH*3-1:0] eq_code;
  logic [NCH*2-1:0] amp_lvl;
  logic [NCH-1:0] ac_term, pwr_en;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign data_io = hdrv ? hval : 'z;

  xpt_cfg_regs u_xpt_cfg_regs (
    .clk(clk), .rst(rst), .chip_en(chip_en), .rd_wr(rd_wr),
    .wr_strobe(wr_strobe), .ctl_sel(ctl_sel), .bank_hi(bank_hi),
    .ch_addr(ch_addr), .data_io(data_io), .eq_code(eq_code),
    .amp_lvl(amp_lvl), .ac_term(ac_term), .pwr_en(pwr_en)
  );

  // {ctl_sel, bank_hi, addr[6:0], data[6:0]}
  localparam logic [15:0] VEC [12] = '{
    {1'b1, 1'b0, 7'd0,   7'h05},
    {1'b1, 1'b0, 7'd67,  7'h1B},
    {1'b1, 1'b0, 7'd10,  7'h2A},
    {1'b1, 1'b0, 7'd33,  7'h57},
    {1'b0, 1'b0, 7'd0,   7'h11},
    {1'b0, 1'b0, 7'd67,  7'h7F},
    {1'b0, 1'b0, 7'd20,  7'h33},
    {1'b0, 1'b1, 7'd0,   7'h22},
    {1'b0, 1'b1, 7'd67,  7'h01},
    {1'b0, 1'b1, 7'd20,  7'h4C},
    {1'b1, 1'b0, 7'd100, 7'h7F},
    {1'b0, 1'b1, 7'd127, 7'h55}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit ce, input bit cs, input bit hi, input logic [6:0] a, input logic [6:0] d);
    @(negedge clk);
    chip_en = ce; rd_wr = 1'b0; ctl_sel = cs; bank_hi = hi; ch_addr = a;
    hdrv = 1'b1; hval = d; wr_strobe = 1'b1;
    @(negedge clk);
    wr_strobe = 1'b0; hdrv = 1'b0; chip_en = 1'b0;
  endtask

  task automatic rd(input bit cs, input bit hi, input logic [6:0] a, output logic [6:0] q);
    @(negedge clk);
    chip_en = 1'b1; rd_wr = 1'b1; ctl_sel = cs; bank_hi = hi; ch_addr = a; hdrv = 1'b0;
    @(negedge clk);
    q = data_io;
    chip_en = 1'b0; rd_wr = 1'b0;
  endtask

  initial begin
    #600000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [6:0] q;
    logic [6:0] exp;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    chk(pwr_en == '1, "R7 pwr_en after reset", int'(pwr_en[31:0]), 32'hFFFFFFFF);
    chk(eq_code == '0 && amp_lvl == '0, "R7 eq/amp after reset", int'(eq_code[31:0]), 0);
    chk(ac_term == '0, "R7 DC coupled after reset", int'(ac_term[31:0]), 0);
    rd(1'b1, 1'b0, 7'd5, q);  chk(q == 7'h00, "R7 ctl reg cleared", q, 0);
    rd(1'b0, 1'b0, 7'd5, q);  chk(q == 7'h00, "R7 mtx reg starts zero", q, 0);

    // vector walk: write all, then read all back
    foreach (VEC[i]) wr(1'b1, VEC[i][15], VEC[i][14], VEC[i][13:7], VEC[i][6:0]);
    foreach (VEC[i]) begin
      rd(VEC[i][15], VEC[i][14], VEC[i][13:7], q);
      exp = (VEC[i][13:7] >= 7'd68) ? 7'h00 : VEC[i][6:0];
      chk(q == exp, "R1 R3 R6 readback", q, exp);
    end
    rd(1'b1, 1'b0, 7'd32, q); chk(q == 7'h00, "R6 no aliasing of addr 100", q, 0);

    // decoded control outputs
    chk(eq_code[0*3 +: 3] == 3'd5, "R8 eq ch0", eq_code[0*3 +: 3], 5);
    chk(eq_code[67*3 +: 3] == 3'd3, "R8 eq ch67", eq_code[67*3 +: 3], 3);
    chk(eq_code[33*3 +: 3] == 3'd7, "R8 eq ch33", eq_code[33*3 +: 3], 7);
    chk(amp_lvl[67*2 +: 2] == 2'd2, "R9 reserved amp saturates", amp_lvl[67*2 +: 2], 2);
    chk(amp_lvl[10*2 +: 2] == 2'd1, "R9 amp ch10", amp_lvl[10*2 +: 2], 1);
    chk(amp_lvl[33*2 +: 2] == 2'd2, "R9 amp ch33", amp_lvl[33*2 +: 2], 2);
    chk(amp_lvl[0*2 +: 2] == 2'd0, "R9 amp ch0", amp_lvl[0*2 +: 2], 0);
    chk(ac_term[10] == 1'b1 && ac_term[0] == 1'b0, "R10 ac_term", ac_term[10], 1);
    chk(pwr_en[33] == 1'b0 && pwr_en[10] == 1'b1, "R10 power-down bit", pwr_en[33], 0);

    // R5: strobe with chip disabled
    wr(1'b0, 1'b1, 1'b0, 7'd1, 7'h7F);
    chk(pwr_en[1] == 1'b1, "R5 disabled write no effect on output", pwr_en[1], 1);
    rd(1'b1, 1'b0, 7'd1, q);  chk(q == 7'h00, "R5 disabled write dropped", q, 0);

    // R2: held strobe writes once
    @(negedge clk);
    chip_en = 1'b1; rd_wr = 1'b0; ctl_sel = 1'b1; ch_addr = 7'd3; hdrv = 1'b1; hval = 7'h01; wr_strobe = 1'b1;
    @(negedge clk); hval = 7'h06;
    repeat (3) @(negedge clk);
    wr_strobe = 1'b0; hdrv = 1'b0; chip_en = 1'b0;
    rd(1'b1, 1'b0, 7'd3, q);  chk(q == 7'h01, "R2 held strobe single write", q, 1);
    chk(eq_code[3*3 +: 3] == 3'd1, "R2 R8 eq ch3", eq_code[3*3 +: 3], 1);

    // R4: bus left to host
    @(negedge clk);
    chip_en = 1'b0; rd_wr = 1'b1; ctl_sel = 1'b1; ch_addr = 7'd0; hdrv = 1'b1; hval = 7'h6A;
    @(negedge clk);
    chk(data_io == 7'h6A, "R4 undriven when disabled", data_io, 7'h6A);
    chip_en = 1'b1; rd_wr = 1'b0; hval = 7'h15;
    @(negedge clk);
    chk(data_io == 7'h15, "R4 undriven in write mode", data_io, 7'h15);
    hdrv = 1'b0; chip_en = 1'b0;

    // R7: reset clears control, matrix survives
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(pwr_en == '1 && eq_code == '0, "R7 control cleared by reset", pwr_en[33], 1);
    rd(1'b1, 1'b0, 7'd0, q);  chk(q == 7'h00, "R7 ctl reg 0 cleared", q, 0);
    rd(1'b0, 1'b0, 7'd0, q);  chk(q == 7'h11, "R7 mtx0 kept", q, 7'h11);
    rd(1'b0, 1'b1, 7'd67, q); chk(q == 7'h01, "R7 R1 mtx1 kept", q, 7'h01);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule